// File: doc/BRIEF.md
# Two-speed start-up clock switcher

This block picks the system clock from two free-running sources: an internal oscillator and an external oscillator, which may be a crystal or resonator or a plain clock input. When the external source is a crystal or resonator, it needs time to settle. A start-up timer counts a configured number of its cycles before that source is trusted. With the dual-start option on, the system runs from the internal oscillator at once while the timer counts. When the count completes, the system clock is handed to the external source without any runt pulse.

The handover is break-before-make. The internal source is gated off at one of its own falling edges, and the status flag rises. The output then stays low until the external source is gated on at one of its own falling edges. Each gate enable passes through a synchroniser clocked by the source it gates. The start-up sequence begins when the power-up timer reports expiry after reset. It begins again on every wake from sleep, and the start-up count restarts from zero each time.

A software select register, cleared by reset, can force the internal source. Automatic switching never alters that register.

Top module: `tss_clock_switcher`

## Requirements
- R1: With dual start on, a crystal mode (codes 0, 1 or 2 on `ext_mode`) and select 0, `sys_clk` runs at the internal rate within a few cycles of `pwrt_done` rising, and `ext_ready` is 0.
- R2: In a crystal mode, the external source is not selected before START_COUNT external cycles have elapsed since the start-up sequence began. The handover follows within a few cycles of the count completing.
- R3: After the handover, `sys_clk` runs at the external rate and `ext_ready` is 1, and the internal gate is never open while `ext_ready` is 1.
- R4: `sys_clk` never shows a high or low phase shorter than half the faster source period, and the two source gates are never open together.
- R5: With dual start off in a crystal mode, `sys_clk` stays low and `clk_ok` is 0 until the count completes. After that, the external source is selected.
- R6: For `ext_mode` codes 3 to 7 (non-crystal external), the external source is selected without a start-up count, and `ext_ready` goes to 1.
- R7: The select bit reads 0 after every reset. While it is 1, `sys_clk` runs from the internal source and `ext_ready` stays 0, however long that lasts. It is written through `sel_wr`/`sel_wdata`.
- R8: While `sleep_req` is 1, `sys_clk` is held low, `clk_ok` is 0 and `ext_ready` is 0, and a running start-up count is abandoned. On wake, dual start resumes on the internal source, and the count restarts from zero.
- R9: Before `pwrt_done` has been seen after reset, `sys_clk` stays low and `clk_ok` is 0.
- R10: An automatic switch never changes the select bit.
- R11: `clk_ok` is 1 whenever either source is gated through to `sys_clk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| int_clk | input | 1 | Internal oscillator; also clocks the control logic |
| ext_clk | input | 1 | External oscillator |
| por_n | input | 1 | Asynchronous reset, active low |
| pwrt_done | input | 1 | Power-up timer expired (internal domain) |
| ext_mode | input | 3 | External source kind: 0..2 crystal/resonator, 3..7 direct clock |
| dual_start_en | input | 1 | Configuration enable for running on the internal clock during start-up |
| sel_wr | input | 1 | Write strobe for the select bit |
| sel_wdata | input | 1 | Select value: 1 forces the internal source |
| sleep_req | input | 1 | Device asleep while 1; a fall is a wake |
| sys_clk | output | 1 | Gated system clock |
| ext_ready | output | 1 | Running from the external source after start-up |
| clk_ok | output | 1 | A source is currently gated to the output |
| sel_bit | output | 1 | Current select bit value |

## Verification
The switch is tried from power-up in a crystal mode with dual start on and then with it off. The first run shows the output running at the internal rate during the count, and the second shows it held low. A non-crystal mode run tells an immediate switch apart from a counted one. The handover time is measured against the full count window, which separates a correct count from an early or late one. Sleep is entered both mid-count and after handover, and the time to the switch after wake shows that the count restarted. A forced-internal run that outlasts the count shows that the select bit overrides the automatic switch. Output phase widths are monitored throughout to catch runt pulses at every handover.

// File: rtl/tss_pkg.sv
`timescale 1ns/1ps
package tss_pkg;

   typedef enum logic [2:0] {
      XM_LOWPWR_XTAL = 3'd0,
      XM_STD_XTAL    = 3'd1,
      XM_FAST_XTAL   = 3'd2,
      XM_CLK_IN      = 3'd3,
      XM_EXT_RC      = 3'd4,
      XM_EXT_RC_IO   = 3'd5,
      XM_CLK_IN_ALT  = 3'd6,
      XM_EXT_MISC    = 3'd7
   } ext_mode_e;

   // Crystal and resonator kinds need a settling count before use
   function automatic logic mode_needs_count(ext_mode_e m);
      return (m == XM_LOWPWR_XTAL) || (m == XM_STD_XTAL) || (m == XM_FAST_XTAL);
   endfunction

endpackage

// File: rtl/tss_sync.sv
`timescale 1ns/1ps
module tss_sync #(
   parameter int STAGES   = 2,
   parameter bit NEG_EDGE = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   logic [STAGES-1:0] chain;

   generate
      if (NEG_EDGE) begin : g_fall
         always_ff @(negedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[STAGES-2:0], d};
         end
      end else begin : g_rise
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[STAGES-2:0], d};
         end
      end
   endgenerate

   assign q = chain[STAGES-1];

endmodule

// File: rtl/tss_src_gate.sv
`timescale 1ns/1ps
module tss_src_gate #(
   parameter int STAGES = 2
) (
   input  logic src_clk,
   input  logic rst_n,
   input  logic req,
   output logic en,
   output logic gclk
);

   // Enable changes only at a falling edge of the gated source, so the
   // AND below can never cut a high phase short.
   tss_sync #(.STAGES(STAGES), .NEG_EDGE(1'b1)) u_en_sync (
      .clk   (src_clk),
      .rst_n (rst_n),
      .d     (req),
      .q     (en)
   );

   assign gclk = src_clk & en;

endmodule

// File: rtl/tss_ost_counter.sv
`timescale 1ns/1ps
module tss_ost_counter #(
   parameter int COUNT  = 1024,
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic done
);

   localparam int CW = $clog2(COUNT + 1);
   localparam logic [CW-1:0] LAST = CW'(COUNT);

   logic          run_s;
   logic [CW-1:0] cnt;

   tss_sync #(.STAGES(STAGES), .NEG_EDGE(1'b0)) u_run_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (run),
      .q     (run_s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cnt <= '0;
      else if (!run_s)      cnt <= '0;
      else if (cnt != LAST) cnt <= cnt + 1'b1;
   end

   assign done = (cnt == LAST);

   // R2
   cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run_s && cnt != LAST) |=> (cnt == $past(cnt) + 1'b1));

   // R8
   cnt_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run_s |=> (cnt == '0));

endmodule

// File: rtl/tss_clock_switcher.sv
`timescale 1ns/1ps
module tss_clock_switcher
   import tss_pkg::*;
#(
   parameter int START_COUNT = 1024,
   parameter int SYNC_STAGES = 2
) (
   input  logic       int_clk,
   input  logic       ext_clk,
   input  logic       por_n,
   input  logic       pwrt_done,
   input  logic [2:0] ext_mode,
   input  logic       dual_start_en,
   input  logic       sel_wr,
   input  logic       sel_wdata,
   input  logic       sleep_req,
   output logic       sys_clk,
   output logic       ext_ready,
   output logic       clk_ok,
   output logic       sel_bit
);

   if (START_COUNT < 2) begin : g_bad_count
      $error("START_COUNT must be at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic started, sel_q, ready_q;
   logic cnt_done, done_s;
   logic int_en, ext_en, gclk_int, gclk_ext;
   logic xtal, active, cnt_run, ext_ok, want_ext, want_int;

   assign xtal     = mode_needs_count(ext_mode_e'(ext_mode));
   assign active   = started & ~sleep_req;
   assign cnt_run  = active & xtal & ~sel_q;
   assign ext_ok   = ~xtal | done_s;
   assign want_ext = active & ~sel_q & ext_ok;
   assign want_int = active & (sel_q | (dual_start_en & ~ext_ok));

   always_ff @(posedge int_clk or negedge por_n) begin
      if (!por_n) begin
         started <= 1'b0;
         sel_q   <= 1'b0;
         ready_q <= 1'b0;
      end else begin
         started <= started | pwrt_done;
         if (sel_wr) sel_q <= sel_wdata;
         // flag rises once the internal gate has closed on its falling edge
         ready_q <= want_ext & ~int_en;
      end
   end

   tss_ost_counter #(.COUNT(START_COUNT), .STAGES(SYNC_STAGES)) u_ost (
      .clk   (ext_clk),
      .rst_n (por_n),
      .run   (cnt_run),
      .done  (cnt_done)
   );

   tss_sync #(.STAGES(SYNC_STAGES), .NEG_EDGE(1'b0)) u_done_sync (
      .clk   (int_clk),
      .rst_n (por_n),
      .d     (cnt_done),
      .q     (done_s)
   );

   tss_src_gate #(.STAGES(SYNC_STAGES)) u_gate_int (
      .src_clk (int_clk),
      .rst_n   (por_n),
      .req     (want_int & ~ext_en),
      .en      (int_en),
      .gclk    (gclk_int)
   );

   tss_src_gate #(.STAGES(SYNC_STAGES)) u_gate_ext (
      .src_clk (ext_clk),
      .rst_n   (por_n),
      .req     (want_ext & ~int_en),
      .en      (ext_en),
      .gclk    (gclk_ext)
   );

   assign sys_clk   = gclk_int | gclk_ext;
   assign clk_ok    = int_en | ext_en;
   assign ext_ready = ready_q;
   assign sel_bit   = sel_q;

   // R4
   gate_mutex_chk: assert property (@(posedge int_clk) disable iff (!por_n)
      !(int_en && ext_en));

   // R3
   ready_src_chk: assert property (@(posedge int_clk) disable iff (!por_n)
      ext_ready |-> !int_en);

   // R8
   sleep_flag_chk: assert property (@(posedge int_clk) disable iff (!por_n)
      sleep_req |=> !ext_ready);

   // R10
   sel_hold_chk: assert property (@(posedge int_clk) disable iff (!por_n)
      !sel_wr |=> $stable(sel_bit));

   // R9
   pre_start_chk: assert property (@(posedge int_clk) disable iff (!por_n)
      !started |-> !clk_ok);

endmodule

// File: tb/test_tss_clock_switcher.sv
`timescale 1ns/1ps
module test_tss_clock_switcher;

   localparam int    COUNT  = 1024;
   localparam real   EXT_T  = 10.0;
   localparam real   MIN_SW = COUNT * EXT_T;

   logic       int_clk = 1'b0, ext_clk = 1'b0, por_n = 1'b0, pwrt_done = 1'b0;
   logic [2:0] ext_mode = 3'd1;
   logic       dual_start_en = 1'b1, sel_wr = 1'b0, sel_wdata = 1'b0, sleep_req = 1'b0;
   logic       sys_clk, ext_ready, clk_ok, sel_bit;

   int  n_chk = 0, n_fail = 0, rises = 0, runts = 0;
   real t_edge = -100.0, t_start = 0.0, t_sw = 0.0;

   tss_clock_switcher #(.START_COUNT(COUNT), .SYNC_STAGES(2)) i_tss_clock_switcher (
      .int_clk(int_clk), .ext_clk(ext_clk), .por_n(por_n), .pwrt_done(pwrt_done),
      .ext_mode(ext_mode), .dual_start_en(dual_start_en), .sel_wr(sel_wr),
      .sel_wdata(sel_wdata), .sleep_req(sleep_req), .sys_clk(sys_clk),
      .ext_ready(ext_ready), .clk_ok(clk_ok), .sel_bit(sel_bit)
   );

   initial forever #2 int_clk = ~int_clk;
   initial begin #3; forever #5 ext_clk = ~ext_clk; end

   always @(posedge sys_clk) rises++;
   always @(sys_clk) begin
      if ($realtime - t_edge < 1.9) runts++;
      t_edge = $realtime;
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // rising edges over 200 ns: 50 for internal, 20 for external, 0 for held low
   task automatic rate_is(input int exp, input string req);
      int r0;
      r0 = rises;
      #200;
      chk((rises - r0 >= exp - 1) && (rises - r0 <= exp + 1), req, "sys_clk rises per 200ns",
          rises - r0, exp);
   endtask

   task automatic power_up(input logic [2:0] mode, input logic dual);
      por_n = 1'b0; pwrt_done = 1'b0; sleep_req = 1'b0; sel_wr = 1'b0;
      ext_mode = mode; dual_start_en = dual;
      #50;
      @(negedge int_clk) por_n = 1'b1;
      repeat (10) @(negedge int_clk);
      chk(clk_ok == 1'b0, "R9", "clk_ok before pwrt", clk_ok, 0);
      chk(sel_bit == 1'b0, "R7", "sel_bit after reset", sel_bit, 0);
      rate_is(0, "R9");
      @(negedge int_clk) pwrt_done = 1'b1;
      t_start = $realtime;
   endtask

   task automatic write_sel(input logic v);
      @(negedge int_clk) begin sel_wr = 1'b1; sel_wdata = v; end
      @(negedge int_clk) sel_wr = 1'b0;
   endtask

   task automatic wait_ready(input int limit);
      for (int i = 0; i < limit; i++) begin
         @(negedge int_clk);
         if (ext_ready) break;
      end
      t_sw = $realtime;
   endtask

   task automatic t_two_speed();
      power_up(3'd1, 1'b1);
      #60;
      rate_is(50, "R1");
      chk(ext_ready == 1'b0, "R1", "ext_ready during count", ext_ready, 0);
      chk(clk_ok == 1'b1, "R11", "clk_ok on internal", clk_ok, 1);
      #9700;
      chk(ext_ready == 1'b0, "R2", "ext_ready before count end", ext_ready, 0);
      wait_ready(1000);
      chk(ext_ready == 1'b1, "R2", "ext_ready after count", ext_ready, 1);
      chk((t_sw - t_start >= MIN_SW) && (t_sw - t_start <= MIN_SW + 300.0), "R2",
          "switch time ns", int'(t_sw - t_start), int'(MIN_SW));
      #80;
      rate_is(20, "R3");
      chk(ext_ready == 1'b1, "R3", "ext_ready on external", ext_ready, 1);
      chk(clk_ok == 1'b1, "R11", "clk_ok on external", clk_ok, 1);
      chk(sel_bit == 1'b0, "R10", "sel_bit after auto switch", sel_bit, 0);
   endtask

   task automatic t_no_dual();
      power_up(3'd2, 1'b0);
      #60;
      rate_is(0, "R5");
      chk(clk_ok == 1'b0, "R5", "clk_ok during count", clk_ok, 0);
      wait_ready(4000);
      chk(t_sw - t_start >= MIN_SW, "R5", "switch time ns", int'(t_sw - t_start), int'(MIN_SW));
      #80;
      rate_is(20, "R5");
   endtask

   task automatic t_direct(input logic [2:0] mode, input logic dual);
      power_up(mode, dual);
      #100;
      chk(ext_ready == 1'b1, "R6", "ext_ready without count", ext_ready, 1);
      rate_is(20, "R6");
   endtask

   task automatic t_sw_select();
      power_up(3'd0, 1'b1);
      #60;
      write_sel(1'b1);
      #60;
      chk(sel_bit == 1'b1, "R7", "sel_bit written", sel_bit, 1);
      rate_is(50, "R7");
      #11000;
      chk(ext_ready == 1'b0, "R7", "ext_ready with select set", ext_ready, 0);
      rate_is(50, "R7");
   endtask

   task automatic t_sleep();
      real t_wake;
      power_up(3'd1, 1'b1);
      #5000;
      @(negedge int_clk) sleep_req = 1'b1;
      #100;
      chk(ext_ready == 1'b0, "R8", "ext_ready asleep", ext_ready, 0);
      chk(clk_ok == 1'b0, "R8", "clk_ok asleep", clk_ok, 0);
      rate_is(0, "R8");
      @(negedge int_clk) sleep_req = 1'b0;
      t_wake = $realtime;
      #60;
      rate_is(50, "R8");
      #9500;
      chk(ext_ready == 1'b0, "R8", "ext_ready before restarted count ends", ext_ready, 0);
      wait_ready(1000);
      chk((t_sw - t_wake >= MIN_SW) && ext_ready, "R8", "switch time after wake ns",
          int'(t_sw - t_wake), int'(MIN_SW));
      #80;
      rate_is(20, "R8");
      @(negedge int_clk) sleep_req = 1'b1;
      #100;
      chk(ext_ready == 1'b0, "R8", "ext_ready asleep after switch", ext_ready, 0);
      rate_is(0, "R8");
      @(negedge int_clk) sleep_req = 1'b0;
      #60;
      rate_is(50, "R8");
   endtask

   initial begin
      #400000;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end

   initial begin
      t_two_speed();
      t_no_dual();
      t_direct(3'd3, 1'b1);
      t_direct(3'd6, 1'b0);
      t_sw_select();
      t_sleep();
      chk(runts == 0, "R4", "short sys_clk phases", runts, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end

endmodule